// File: doc/BRIEF.md
# Dual-Bank Synchronous Burst SRAM

This block is a synthesizable behavioural model of a 72-bit-wide synchronous static memory split into two banks. The banks share one address bus, one set of write controls and one set of burst controls. Each bank has its own active-low select. Every control input is sampled on the rising clock edge. Reads are flow-through: the word at the registered address appears on the output during the cycle that follows the sampling edge, and no output register sits in the path.

There are two start strobes. The read strobe opens a read burst. The load strobe opens a read or a write burst, and which one depends on the write controls. When both strobes are high, a step input either moves the burst to its next location or holds the current location as a wait cycle. If the load strobe is held low on every cycle, the memory runs as a plain synchronous RAM with a fresh address each cycle and early writes. The word is organised as eight 9-bit lanes. Writes can cover all lanes at once or only the lanes selected by the per-lane enables. An asynchronous output enable gates the read data.

The pad-level bus is modelled as separate write-data and read-data ports together with a read-valid flag. The memory depth is set by a parameter.

Top module: `dual_bank_burst_sram`

## Requirements
- R1: During reset and after it, until an access starts, `rvalid` is 0 and `rdata` and `rpar` are 0.
- R2: The read data is flow-through. After the edge that samples a read of address A in bank B, `{rpar,rdata}` shows the stored word at B:A for the whole following cycle. With `load_n` held low on every cycle, each cycle takes a fresh address.
- R3: `load_rd_n` low while at least one bank select is low starts a read at `addr_i`, and the write controls are ignored on that edge. If `load_rd_n` is low while both selects are high, the device is deselected.
- R4: `load_n` low, with `load_rd_n` high and a bank selected, starts an access at `addr_i`. The access is a write when the write controls request one and a read otherwise. A write takes its data on the same edge (early write), and no read data is shown in the following cycle.
- R5: When both strobes are high and `step_n` is low, the burst moves to the next location. The two low address bits count up modulo 4 and the upper bits stay unchanged, so a start at 9 visits 9, 10, 11, 8.
- R6: When both strobes are high and `step_n` is high, the burst holds its current location. A read shows the same word again. A write stores the new data into that same location.
- R7: `wr_all_n` low writes all 64 data bits and all 8 parity bits, whatever `wr_byte_n` and `lane_n` are set to.
- R8: When `wr_all_n` is high and `wr_byte_n` is low, each lane n whose `lane_n[n]` is low is written. Lane n is data bits 8n..8n+7 together with parity bit n. Lanes whose enable is high keep their old contents. When `wr_byte_n` is high and `wr_all_n` is high, nothing is written and the cycle is a read.
- R9: A start strobe with both bank selects high deselects the device. The output stays invalid through the continue and wait cycles that follow, until the next start.
- R10: If both bank selects are low at a start, bank 0 (`bank_sel_n[0]`) is the only bank that responds. The bank chosen at a start is kept through the whole burst, and the selects are ignored in continue and wait cycles.
- R11: `out_en_n` acts combinationally. Read data is valid only while it is low, and it takes effect without waiting for a clock edge.
- R12: Whenever `rvalid` is 0, `rdata` and `rpar` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External word address |
| bank_sel_n | input | 2 | Active-low bank selects; bit 0 is bank 0 |
| load_rd_n | input | 1 | Read start strobe, active low; gated by the bank selects |
| load_n | input | 1 | Load start strobe, active low; read or write |
| step_n | input | 1 | Burst advance when low, wait cycle when high |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Enables lane-masked writes, active low |
| lane_n | input | 8 | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 64 | Write data, lane n in bits 8n+7:8n |
| wpar | input | 8 | Write parity, bit n belongs to lane n |
| rdata | output | 64 | Read data, zero when not valid |
| rpar | output | 8 | Read parity, zero when not valid |
| rvalid | output | 1 | Read data is being driven |

## Verification
The bench sets `ADDR_W` to 4, which gives 16 words per bank. At that size every location in both banks can be preloaded with a known pattern in 32 cycles, so every read can be compared against a fully known reference image, and a write that lands in the wrong place (a carry out of the burst counter, the wrong bank) shows up as a mismatch at a location the bench has already filled. A burst started at address 9 wraps within its group of four, and a wrong carry into bit 2 would disturb location 12, which the bench reads back.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANES  = 8;
    localparam int LANE_D = 8;
    localparam int DATA_W = LANES * LANE_D;
    localparam int WORD_W = DATA_W + LANES;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_START,
        CYC_DESEL,
        CYC_NEXT,
        CYC_HOLD
    } cyc_e;

    // Sequential burst order: low two address bits count up, wrapping at four.
    function automatic logic [1:0] burst_next(input logic [1:0] cur);
        return cur + 2'd1;
    endfunction
endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bank_sel_n,
    input  logic              load_rd_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_bank,
    output logic              rd_live
);
    typedef struct packed {
        logic              active;
        logic              bank;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t             st_d, st_q;
    cyc_e             kind;
    logic             any_sel;
    logic             wr_req;
    logic [LANES-1:0] lane_mask;

    always_comb begin
        any_sel   = (bank_sel_n != 2'b11);
        lane_mask = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_n : '0);
        wr_req    = |lane_mask;

        if (!load_rd_n || !load_n)
            kind = any_sel ? CYC_START : CYC_DESEL;
        else if (!st_q.active)
            kind = CYC_IDLE;
        else if (!step_n)
            kind = CYC_NEXT;
        else
            kind = CYC_HOLD;

        st_d = st_q;
        unique case (kind)
            CYC_START: begin
                st_d.active = 1'b1;
                st_d.bank   = bank_sel_n[0];
                st_d.addr   = addr_i;
                st_d.wr     = load_rd_n ? wr_req : 1'b0;
            end
            CYC_DESEL: begin
                st_d.active = 1'b0;
                st_d.wr     = 1'b0;
            end
            CYC_NEXT: begin
                st_d.addr = {st_q.addr[ADDR_W-1:2], burst_next(st_q.addr[1:0])};
                st_d.wr   = wr_req;
            end
            CYC_HOLD: begin
                st_d.wr = wr_req;
            end
            default: ;
        endcase

        mem_addr = st_d.addr;
        wr_bank  = st_d.bank;
        wr_lanes = (st_d.active && st_d.wr) ? lane_mask : '0;
        rd_addr  = st_q.addr;
        rd_bank  = st_q.bank;
        rd_live  = st_q.active && !st_q.wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bsram_bank.sv
module bsram_bank
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  wpar,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int n = 0; n < LANES; n++) begin
            if (wr_lane[n]) begin
                mem[waddr][n*LANE_D +: LANE_D] <= wdata[n*LANE_D +: LANE_D];
                mem[waddr][DATA_W + n]         <= wpar[n];
            end
        end
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/dual_bank_burst_sram.sv
module dual_bank_burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bank_sel_n,
    input  logic              load_rd_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [7:0]        lane_n,
    input  logic              out_en_n,
    input  logic [63:0]       wdata,
    input  logic [7:0]        wpar,
    output logic [63:0]       rdata,
    output logic [7:0]        rpar,
    output logic              rvalid
);
    localparam int NBANK = 2;

    logic [ADDR_W-1:0] mem_addr, rd_addr;
    logic [LANES-1:0]  wr_lanes;
    logic              wr_bank, rd_bank, rd_live;
    logic [WORD_W-1:0] bank_word [NBANK];
    logic [WORD_W-1:0] sel_word;

    bsram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .bank_sel_n(bank_sel_n),
        .load_rd_n (load_rd_n),
        .load_n    (load_n),
        .step_n    (step_n),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_n    (lane_n),
        .mem_addr  (mem_addr),
        .wr_lanes  (wr_lanes),
        .wr_bank   (wr_bank),
        .rd_addr   (rd_addr),
        .rd_bank   (rd_bank),
        .rd_live   (rd_live)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bsram_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk    (clk),
            .waddr  (mem_addr),
            .wr_lane((wr_bank == 1'(b)) ? wr_lanes : '0),
            .wdata  (wdata),
            .wpar   (wpar),
            .raddr  (rd_addr),
            .rword  (bank_word[b])
        );
    end

    always_comb begin
        sel_word = rd_bank ? bank_word[1] : bank_word[0];
        rvalid   = rd_live && !out_en_n;
        {rpar, rdata} = rvalid ? sel_word : '0;
    end
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bank_sel_n,
    input logic        load_rd_n,
    input logic        load_n,
    input logic        step_n,
    input logic        wr_all_n,
    input logic        wr_byte_n,
    input logic        out_en_n,
    input logic [63:0] rdata,
    input logic [7:0]  rpar,
    input logic        rvalid
);
    // R9: a start with no bank selected leaves nothing driven next cycle
    p_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((!load_rd_n || !load_n) && bank_sel_n == 2'b11) |=> !rvalid);

    // R3: a read start with a bank selected shows data next cycle unless gated
    p_rdstart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_rd_n && bank_sel_n != 2'b11) |=> (out_en_n || rvalid));

    // R4: a load-strobe write start shows no read data in the next cycle
    p_wrstart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rd_n && !load_n && bank_sel_n != 2'b11 && !wr_all_n) |=> !rvalid);

    // R6: a wait cycle with no write repeats the same word
    p_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_rd_n && load_n && step_n && wr_all_n && wr_byte_n && rvalid)
        |=> (out_en_n || (rvalid && $stable({rpar, rdata}))));

    // R11: output enable high means no valid data
    p_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rvalid);

    // R12: invalid output is all zero
    p_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0 && rpar == '0));
endmodule

bind dual_bank_burst_sram bsram_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel_n(bank_sel_n),
    .load_rd_n (load_rd_n),
    .load_n    (load_n),
    .step_n    (step_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .out_en_n  (out_en_n),
    .rdata     (rdata),
    .rpar      (rpar),
    .rvalid    (rvalid)
);

// File: tb/sim_dual_bank_burst_sram.sv
module sim_dual_bank_burst_sram;
    localparam int AW = 4;
    localparam int DEP = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic [1:0]    bank_sel_n;
    logic          load_rd_n, load_n, step_n, wr_all_n, wr_byte_n, out_en_n;
    logic [7:0]    lane_n;
    logic [63:0]   wdata;
    logic [7:0]    wpar;
    logic [63:0]   rdata;
    logic [7:0]    rpar;
    logic          rvalid;

    logic [71:0] ref_m [2][DEP];
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dual_bank_burst_sram #(.ADDR_W(AW)) u0 (.*);

    function automatic logic [71:0] pat(input int i);
        return {8'(i * 37 + 5), 64'h0f1e_2d3c_4b5a_6978 ^ (64'(i) * 64'h0101_0301_0107_0113)};
    endfunction

    task automatic chk(input string req, input logic [71:0] got, input logic [71:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic idle();
        load_rd_n = 1; load_n = 1; step_n = 1; bank_sel_n = 2'b11;
        wr_all_n = 1; wr_byte_n = 1; lane_n = '1; out_en_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ref_wr(input int b, input int a, input logic [71:0] w, input logic [7:0] m);
        for (int n = 0; n < 8; n++)
            if (m[n]) begin
                ref_m[b][a][n*8 +: 8] = w[n*8 +: 8];
                ref_m[b][a][64+n]     = w[64+n];
            end
    endtask

    task automatic expect_rd(input string req, input int b, input int a);
        chk(req, {71'd0, rvalid}, 72'd1);
        chk(req, {rpar, rdata}, ref_m[b][a]);
    endtask

    task automatic sync_wr(input int b, input int a, input logic [71:0] w);
        idle(); load_n = 0; bank_sel_n = (b == 0) ? 2'b10 : 2'b01;
        addr_i = AW'(a); wr_all_n = 0; {wpar, wdata} = w;
        tick(); ref_wr(b, a, w, 8'hff);
    endtask

    task automatic sync_rd(input string req, input int b, input int a);
        idle(); load_n = 0; bank_sel_n = (b == 0) ? 2'b10 : 2'b01; addr_i = AW'(a);
        tick(); expect_rd(req, b, a);
    endtask

    task automatic t_reset();
        idle(); rst_n = 0; addr_i = '0; wdata = '0; wpar = '0;
        tick(); tick();
        chk("R1 in reset", {rvalid, rpar, rdata[62:0]}, 72'd0);
        rst_n = 1; tick();
        chk("R1 after reset", {rvalid, rpar, rdata[62:0]}, 72'd0);
        chk("R12 idle data", {8'd0, rdata}, 72'd0);
    endtask

    task automatic t_preload();
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < DEP; a++) begin
                sync_wr(b, a, pat(b * 64 + a));
                chk("R4 write cycle no data", {71'd0, rvalid}, 72'd0);
            end
        for (int a = 0; a < DEP; a += 3) begin
            sync_rd("R2 sync read bank0", 0, a);
            sync_rd("R2 sync read bank1", 1, a);
        end
    endtask

    task automatic t_global();
        idle(); load_n = 0; bank_sel_n = 2'b10; addr_i = 4'd3;
        wr_all_n = 0; wr_byte_n = 1; lane_n = 8'h5a; {wpar, wdata} = pat(200);
        tick(); ref_wr(0, 3, pat(200), 8'hff);
        sync_rd("R7 global write all lanes", 0, 3);
    endtask

    task automatic t_bytes();
        idle(); load_n = 0; bank_sel_n = 2'b10; addr_i = 4'd2;
        wr_byte_n = 0; lane_n = 8'b1010_0110; {wpar, wdata} = pat(300);
        tick(); ref_wr(0, 2, pat(300), 8'b0101_1001);
        sync_rd("R8 lane write", 0, 2);
        idle(); load_n = 0; bank_sel_n = 2'b10; addr_i = 4'd2;
        wr_byte_n = 1; lane_n = 8'h00; {wpar, wdata} = pat(301);
        tick();
        expect_rd("R8 no byte mode is read", 0, 2);
    endtask

    task automatic t_rdstart();
        idle(); load_rd_n = 0; bank_sel_n = 2'b10; addr_i = 4'd2;
        wr_all_n = 0; {wpar, wdata} = pat(400);
        tick();
        expect_rd("R3 read start ignores write", 0, 2);
        idle(); load_rd_n = 0; bank_sel_n = 2'b11; tick();
        chk("R3 read strobe no bank", {71'd0, rvalid}, 72'd0);
    endtask

    task automatic t_burst_rd();
        idle(); load_rd_n = 0; bank_sel_n = 2'b01; addr_i = 4'd6; tick();
        expect_rd("R5 burst beat 1", 1, 6);
        idle(); step_n = 0; bank_sel_n = 2'b10; tick();
        expect_rd("R10 bank held, beat 2", 1, 7);
        tick();
        expect_rd("R5 wrap beat 3", 1, 4);
        step_n = 1; tick();
        expect_rd("R6 suspend repeats", 1, 4);
        step_n = 0; tick();
        expect_rd("R5 beat 4", 1, 5);
    endtask

    task automatic t_burst_wr();
        idle(); load_n = 0; bank_sel_n = 2'b01; addr_i = 4'd9;
        wr_all_n = 0; {wpar, wdata} = pat(500);
        tick(); ref_wr(1, 9, pat(500), 8'hff);
        load_n = 1; step_n = 0; {wpar, wdata} = pat(501);
        tick(); ref_wr(1, 10, pat(501), 8'hff);
        {wpar, wdata} = pat(502); tick(); ref_wr(1, 11, pat(502), 8'hff);
        {wpar, wdata} = pat(503); tick(); ref_wr(1, 8, pat(503), 8'hff);
        step_n = 1; {wpar, wdata} = pat(504); tick(); ref_wr(1, 8, pat(504), 8'hff);
        for (int a = 8; a < 13; a++) sync_rd("R5 R6 burst write image", 1, a);
    endtask

    task automatic t_desel();
        idle(); load_n = 0; bank_sel_n = 2'b11; tick();
        chk("R9 deselect", {71'd0, rvalid}, 72'd0);
        idle(); step_n = 0; tick();
        chk("R9 stays deselected", {rpar, rdata}, 72'd0);
        chk("R9 stays deselected valid", {71'd0, rvalid}, 72'd0);
    endtask

    task automatic t_prio();
        idle(); load_n = 0; bank_sel_n = 2'b00; addr_i = 4'd5;
        wr_all_n = 0; {wpar, wdata} = pat(600);
        tick(); ref_wr(0, 5, pat(600), 8'hff);
        sync_rd("R10 bank1 untouched", 1, 5);
        sync_rd("R10 bank0 got write", 0, 5);
    endtask

    task automatic t_oe();
        sync_rd("R2 read before oe", 1, 1);
        out_en_n = 1; #1;
        chk("R11 oe high", {rvalid, rpar, rdata[62:0]}, 72'd0);
        out_en_n = 0; #1;
        expect_rd("R11 oe low again", 1, 1);
    endtask

    initial begin
        #(20 * 50000);
        bad++; total++;
        $display("FAIL watchdog got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_preload();
        t_global();
        t_bytes();
        t_rdstart();
        t_burst_rd();
        t_burst_wr();
        t_desel();
        t_prio();
        t_oe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule